// File: doc/BRIEF.md
# Halt Instruction Disposition Controller

This block settles what the processor does once its instruction decoder has recognised a HALT. It takes a one-cycle HALT strobe, the current privilege mode (user or kernel), an asynchronous power-good level and a static halt/trap strap. It answers with exactly one of three single-cycle action pulses: take a trap through vector 10 octal, hand control to the console, or restart the full power-up sequence.

A HALT in user mode always traps. A HALT in kernel mode first tests the power-good level. If power is good, the strap chooses the action: removed selects console entry and installed selects a trap. If power is not good, the block stays in a polling state until power-good returns, and then asks for a power-up sequence. The power-good input first passes through a flop chain of parameterised depth (two by default). The trap microsequence, the console and the power-up sequencer are downstream of the three pulses.

Top module: `halt_disposition`

## Requirements
- R1: While rst_ni is low, and on the first clock after it rises, trap_o, console_o and powerup_o are 0 and trap_vec_o is 0.
- R2: A halt_i strobe in idle with user_mode_i=1 produces trap_o=1 in the cycle after the strobe edge, whatever trap_strap_i and pwr_ok_i are.
- R3: A halt_i strobe in idle with user_mode_i=0, a synchronised power-good of 1 and trap_strap_i=0 (strap removed) produces console_o=1 in the next cycle.
- R4: A halt_i strobe in idle with user_mode_i=0, a synchronised power-good of 1 and trap_strap_i=1 (strap installed) produces trap_o=1 in the next cycle.
- R5: A halt_i strobe in idle with user_mode_i=0 and a synchronised power-good of 0 produces no action, and no action follows for as long as pwr_ok_i stays 0.
- R6: While polling, a rise of pwr_ok_i first seen at clock edge n gives powerup_o=1 after edge n+2, one cycle after the two synchroniser stages and the state register.
- R7: Every action is a one-cycle pulse, at most one of trap_o, console_o and powerup_o is 1 at a time, and a new strobe is accepted in the cycle after a pulse.
- R8: halt_i strobes that arrive while a pulse is out or while polling produce no extra action.
- R9: trap_vec_o shows 8 (10 octal) while trap_o is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_i | input | 1 | HALT decoded strobe, one cycle |
| user_mode_i | input | 1 | 1 = user mode, 0 = kernel mode |
| pwr_ok_i | input | 1 | Power-good level, asynchronous |
| trap_strap_i | input | 1 | 1 = strap installed (trap), 0 = removed (console) |
| trap_o | output | 1 | Trap request pulse |
| trap_vec_o | output | VEC_W | Trap vector, valid with trap_o |
| console_o | output | 1 | Console entry pulse |
| powerup_o | output | 1 | Power-up sequence request pulse |

## Verification
The hardest path to reach is a kernel-mode HALT with power bad, followed by the exit from polling. It needs pwr_ok_i held low through the synchroniser before the strobe, then a later rise whose pulse arrives only after the synchroniser and state delays. The stimulus settles random power levels for three cycles before each strobe. It sends random extra strobes during polling and on pulse cycles. It then raises power and checks the exact cycle of powerup_o against the three-edge latency.

// File: rtl/halt_disp_pkg.sv
package halt_disp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL,
    ST_TRAP,
    ST_CONSOLE,
    ST_POWERUP
  } hd_state_e;

  typedef enum logic [1:0] {
    ACT_WAIT,
    ACT_TRAP,
    ACT_CONSOLE
  } hd_act_e;
endpackage

// File: rtl/halt_sync.sv
module halt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[0] <= 1'b0;
        else         chain_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b0;
        else         chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/halt_decide.sv
module halt_decide
  import halt_disp_pkg::*;
(
  input  logic    user_mode_i,
  input  logic    pwr_ok_i,
  input  logic    trap_strap_i,
  output hd_act_e act_o
);
  always_comb begin
    if (user_mode_i)       act_o = ACT_TRAP;
    else if (!pwr_ok_i)    act_o = ACT_WAIT;
    else if (trap_strap_i) act_o = ACT_TRAP;
    else                   act_o = ACT_CONSOLE;
  end
endmodule

// File: rtl/halt_fsm.sv
module halt_fsm
  import halt_disp_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    halt_i,
  input  hd_act_e act_i,
  input  logic    pwr_ok_i,
  output logic    idle_o,
  output logic    trap_o,
  output logic    console_o,
  output logic    powerup_o
);
  hd_state_e state_q, state_d;

  always_comb begin
    state_d = ST_IDLE;
    unique case (state_q)
      ST_IDLE: begin
        if (halt_i) begin
          unique case (act_i)
            ACT_TRAP:    state_d = ST_TRAP;
            ACT_CONSOLE: state_d = ST_CONSOLE;
            default:     state_d = ST_POLL;
          endcase
        end
      end
      ST_POLL: state_d = pwr_ok_i ? ST_POWERUP : ST_POLL;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign idle_o    = (state_q == ST_IDLE);
  assign trap_o    = (state_q == ST_TRAP);
  assign console_o = (state_q == ST_CONSOLE);
  assign powerup_o = (state_q == ST_POWERUP);

  AST_POLL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POLL && !pwr_ok_i) |=> (state_q == ST_POLL)); // R5
  AST_POLL_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POLL && pwr_ok_i) |=> powerup_o); // R6
  AST_PULSE_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o || console_o || powerup_o) |=> idle_o); // R8
endmodule

// File: rtl/halt_disposition.sv
module halt_disposition
  import halt_disp_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter int               VEC_W       = 8,
  parameter logic [VEC_W-1:0] TRAP_VEC    = 8'o10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             halt_i,
  input  logic             user_mode_i,
  input  logic             pwr_ok_i,
  input  logic             trap_strap_i,
  output logic             trap_o,
  output logic [VEC_W-1:0] trap_vec_o,
  output logic             console_o,
  output logic             powerup_o
);
  logic    pwr_ok_s;
  logic    idle;
  hd_act_e act;

  halt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pwr_ok_i),
    .q_o   (pwr_ok_s)
  );

  halt_decide u_decide (
    .user_mode_i (user_mode_i),
    .pwr_ok_i    (pwr_ok_s),
    .trap_strap_i(trap_strap_i),
    .act_o       (act)
  );

  halt_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .halt_i   (halt_i),
    .act_i    (act),
    .pwr_ok_i (pwr_ok_s),
    .idle_o   (idle),
    .trap_o   (trap_o),
    .console_o(console_o),
    .powerup_o(powerup_o)
  );

  assign trap_vec_o = trap_o ? TRAP_VEC : '0;

  AST_USER_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && halt_i && user_mode_i) |=> trap_o); // R2
  AST_KERNEL_CONSOLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && halt_i && !user_mode_i && pwr_ok_s && !trap_strap_i) |=> console_o); // R3
  AST_KERNEL_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && halt_i && !user_mode_i && pwr_ok_s && trap_strap_i) |=> trap_o); // R4
  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o || console_o || powerup_o) |=> !(trap_o || console_o || powerup_o)); // R7
  AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({trap_o, console_o, powerup_o})); // R7
endmodule

// File: tb/halt_disposition_test.sv
module halt_disposition_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 50000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       halt = 1'b0, user = 1'b0, pwr = 1'b0, strap = 1'b0;
  logic       trap, console, powerup;
  logic [7:0] vec;
  int         n_chk = 0, n_bad = 0, cycles = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halt_disposition uut (
    .clk_i(clk), .rst_ni(rst_ni), .halt_i(halt), .user_mode_i(user),
    .pwr_ok_i(pwr), .trap_strap_i(strap), .trap_o(trap), .trap_vec_o(vec),
    .console_o(console), .powerup_o(powerup)
  );

  // packed expected outputs: {trap, console, powerup, vec}
  function automatic logic [10:0] pack(logic t, logic c, logic p);
    return {t, c, p, t ? 8'd8 : 8'd0};
  endfunction

  // 0 = wait for power, 1 = trap, 2 = console
  function automatic int exp_action(logic u, logic p, logic s);
    if (u) return 1;
    if (!p) return 0;
    return s ? 1 : 2;
  endfunction

  task automatic check(string req, logic [10:0] exp);
    logic [10:0] act;
    act = {trap, console, powerup, vec};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic settle_pwr(logic p);
    pwr = p;
    repeat (3) tick();
  endtask

  // issue strobe in idle; returns after sampling the cycle after the edge
  task automatic fire(logic u, logic s, logic extra, string req);
    int a;
    user = u; strap = s; halt = 1'b1;
    tick();
    halt = extra;  // R8: strobe during pulse
    a = exp_action(u, pwr, s);
    check(req, pack(a == 1, a == 2, 1'b0));
    tick();
    halt = 1'b0;
    check("R8/R7 after pulse", pack(0, 0, 0));
  endtask

  task automatic poll_then_power(int len);
    for (int i = 0; i < len; i++) begin
      halt = 1'($urandom_range(0, 1));
      user = 1'($urandom_range(0, 1));
      tick();
      check("R5/R8 polling quiet", pack(0, 0, 0));
    end
    halt = 1'b0;
    pwr = 1'b1;
    tick(); check("R6 cycle 1", pack(0, 0, 0));
    tick(); check("R6 cycle 2", pack(0, 0, 0));
    tick(); check("R6 powerup", pack(0, 0, 1));
    tick(); check("R7 powerup single", pack(0, 0, 0));
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    tick();
    check("R1 in reset", pack(0, 0, 0));
    tick();
    rst_ni = 1'b1;
    tick();
    check("R1 after reset", pack(0, 0, 0));

    // directed corners
    settle_pwr(1'b0);
    fire(1'b1, 1'b0, 1'b0, "R2 user trap power bad");
    settle_pwr(1'b1);
    fire(1'b1, 1'b0, 1'b1, "R2 user trap strap out");
    fire(1'b0, 1'b0, 1'b0, "R3 kernel console");
    fire(1'b0, 1'b1, 1'b1, "R4 kernel trap R9 vector");
    fire(1'b0, 1'b0, 1'b0, "R7 back-to-back accept");
    settle_pwr(1'b0);
    user = 1'b0; halt = 1'b1;
    tick(); halt = 1'b0;
    check("R5 kernel power bad", pack(0, 0, 0));
    poll_then_power(6);

    // random
    for (int it = 0; it < 300; it++) begin
      logic u, s, p;
      u = 1'($urandom_range(0, 1));
      s = 1'($urandom_range(0, 1));
      p = 1'($urandom_range(0, 1));
      settle_pwr(p);
      if (!u && !p) begin
        user = 1'b0; strap = s; halt = 1'b1;
        tick(); halt = 1'b0;
        check("R5 random kernel power bad", pack(0, 0, 0));
        poll_then_power($urandom_range(1, 12));
      end else begin
        fire(u, s, 1'($urandom_range(0, 1)), "R2/R3/R4 random");
      end
      repeat ($urandom_range(0, 2)) begin
        tick();
        check("R7 idle quiet", pack(0, 0, 0));
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > MAX_CYCLES && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, MAX_CYCLES);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule